// File: doc/BRIEF.md
# Streaming Max-Log Bit LLR Unit

This block sits behind a soft-output MIMO tree-search detector. For every detection the detector emits a list of candidate symbol vectors, each with a binary label (one symbol label per transmit antenna, concatenated) and an unsigned distance metric. The candidates arrive in fixed-size batches, one batch per valid cycle, and a fixed number of batches makes up one detection. With the default parameters this means four antennas with 8-bit labels (a 32-bit vector label), eight candidates per batch, eight batches and 64 candidates per detection.

The unit never stores the candidate list. For every label bit it keeps two running minima: one over the candidates whose bit is 0 and one over those whose bit is 1. Each valid batch is first reduced to per-bit batch minima by a compare tree. These are then merged with the held minima. After the last batch of a detection, each bit's log-likelihood ratio is formed with the max-log rule as the bit-1 minimum minus the bit-0 minimum, saturated to the output width, and presented with a one-cycle done pulse. A flag on the first batch opens a detection. A new detection may open in the cycle right after the last batch.

Top module: `llr_maxlog_stream`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset is released, `llr_valid` is 0.
- R2: Candidate c uses label bits `in_labels[c*LABEL_W +: LABEL_W]` and metric `in_metrics[c*METRIC_W +: METRIC_W]`. Label bit j feeds the LLR at `llr_out[j*LLR_W +: LLR_W]`. Antenna a's symbol label occupies label bits `[a*SYM_BITS +: SYM_BITS]`.
- R3: LLR j equals min(metric over candidates of the detection with label bit j = 1) minus min(metric over those with bit j = 0), with the metrics taken as unsigned.
- R4: `llr_valid` is high for exactly one cycle, namely the cycle after the NUM_BATCH-th accepted batch of a detection. `llr_out` holds its value until the next such pulse.
- R5: Cycles with `in_valid` low inside a detection are not counted as batches and do not change the result.
- R6: A valid batch with `in_first` high always opens a new detection. Minima and batch count from any unfinished detection are discarded.
- R7: A valid batch with `in_first` low while no detection is open is ignored: no `llr_valid` pulse follows and `llr_out` is unchanged.
- R8: If no candidate of a detection has a given value of bit j, the minimum for that hypothesis is the all-ones metric 2^METRIC_W-1.
- R9: The difference is saturated to the signed LLR_W range [-2^(LLR_W-1), 2^(LLR_W-1)-1]. With the defaults (16-bit metrics, 17-bit LLRs) every difference fits exactly.
- R10: The first batch of a new detection may arrive in the cycle in which `llr_valid` is high. Both detections are then reported correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A candidate batch is present this cycle |
| in_first | input | 1 | This batch opens a new detection |
| in_labels | input | NUM_CAND*LABEL_W | Vector labels of the batch, candidate 0 in the low bits |
| in_metrics | input | NUM_CAND*METRIC_W | Unsigned metrics of the batch, candidate 0 in the low bits |
| llr_valid | output | 1 | One-cycle pulse: a detection's LLRs are on `llr_out` |
| llr_out | output | LABEL_W*LLR_W | Signed LLR per label bit, bit 0 in the low field |

## Verification
The bench builds the block with two antennas of 2-bit labels, two candidates per batch, three batches per detection, 4-bit metrics and 4-bit LLRs. With 4-bit metrics every pair of bit-0 and bit-1 minima can be swept, so each saturation corner and each tie between the two minima is reached. An odd batch count exercises the counter away from a power of two. The same small size lets long streams of generated detections, with idle gaps, aborts, stray batches and back-to-back starts, run against a model of the two minima per bit.

// File: rtl/llr_pkg.sv
// Package: shared defaults and the control phase type of the max-log LLR unit.
// Assumes: each default describes a 4-antenna, 256-QAM detection of 64 candidates.
package llr_pkg;
    localparam int DEF_NUM_ANT   = 4;
    localparam int DEF_SYM_BITS  = 8;
    localparam int DEF_NUM_CAND  = 8;
    localparam int DEF_NUM_BATCH = 8;
    localparam int DEF_METRIC_W  = 16;
    localparam int DEF_LLR_W     = 17;

    typedef enum logic {
        PH_IDLE    = 1'b0,
        PH_COLLECT = 1'b1
    } phase_e;
endpackage

// File: rtl/llr_ctrl.sv
// Module: batch sequencing of one detection.
// Counts the accepted batches, opens a detection on a flagged first batch,
// flags the last batch and registers the done pulse.
// Assumes: NUM_BATCH >= 1. In idle, unflagged batches are dropped.
module llr_ctrl #(
    parameter int NUM_BATCH = llr_pkg::DEF_NUM_BATCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_first,
    output logic accept,
    output logic restart,
    output logic last,
    output logic done
);
    import llr_pkg::*;

    localparam int CNT_W = (NUM_BATCH > 1) ? $clog2(NUM_BATCH + 1) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BATCH - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    // Decode this cycle's batch: open, continue or ignore, and whether it is the last.
    always_comb begin
        restart = in_valid && in_first;
        accept  = in_valid && (in_first || (phase == PH_COLLECT));
        if (restart) begin
            last = (NUM_BATCH == 1);
        end else begin
            last = accept && (cnt == LAST_IDX);
        end
    end

    // Advance the batch count and the phase, and register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else if (restart) begin
                phase <= PH_COLLECT;
                cnt   <= CNT_W'(1);
            end else if (accept) begin
                cnt   <= cnt + CNT_W'(1);
            end
        end
    end

    // The batch count never reaches NUM_BATCH.
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(NUM_BATCH));

    // A done pulse only follows a valid input batch.
    assert_done_after_batch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));

    // A stray batch in idle produces no done pulse.
    assert_stray_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && in_valid && !in_first) |=> !done);
endmodule

// File: rtl/llr_cand_tree.sv
// Module: per-bit batch reduction.
// For one label bit, it finds the smallest metric among this batch's
// candidates whose bit is 0 and the smallest among those whose bit is 1.
// Assumes: metrics unsigned. A candidate excluded from a hypothesis counts
// as the all-ones value. On a tie the lower-index branch wins.
module llr_cand_tree #(
    parameter int NUM_CAND = llr_pkg::DEF_NUM_CAND,
    parameter int METRIC_W = llr_pkg::DEF_METRIC_W
) (
    input  logic [NUM_CAND-1:0]          bit_vals,
    input  logic [NUM_CAND*METRIC_W-1:0] metrics,
    output logic [METRIC_W-1:0]          min0,
    output logic [METRIC_W-1:0]          min1
);
    localparam int DEPTH  = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 0;
    localparam int LEAVES = 1 << DEPTH;
    localparam logic [METRIC_W-1:0] M_MAX = '1;

    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        localparam int N = LEAVES >> l;
        logic [METRIC_W-1:0] n0 [N];
        logic [METRIC_W-1:0] n1 [N];
        for (genvar i = 0; i < N; i++) begin : g_node
            if (l == 0) begin : g_leaf
                if (i < NUM_CAND) begin : g_real
                    // Route the candidate metric to the hypothesis its bit selects.
                    assign n0[i] = bit_vals[i] ? M_MAX : metrics[i*METRIC_W +: METRIC_W];
                    assign n1[i] = bit_vals[i] ? metrics[i*METRIC_W +: METRIC_W] : M_MAX;
                end else begin : g_pad
                    assign n0[i] = M_MAX;
                    assign n1[i] = M_MAX;
                end
            end else begin : g_cmp
                // Pairwise minimum, left branch kept on equality.
                assign n0[i] = (g_lvl[l-1].n0[2*i+1] < g_lvl[l-1].n0[2*i])
                             ? g_lvl[l-1].n0[2*i+1] : g_lvl[l-1].n0[2*i];
                assign n1[i] = (g_lvl[l-1].n1[2*i+1] < g_lvl[l-1].n1[2*i])
                             ? g_lvl[l-1].n1[2*i+1] : g_lvl[l-1].n1[2*i];
            end
        end
    end

    assign min0 = g_lvl[DEPTH].n0[0];
    assign min1 = g_lvl[DEPTH].n1[0];
endmodule

// File: rtl/llr_min_acc.sv
// Module: running-minimum pair for one label bit.
// Merges the batch minima into the held minima. A restart uses the
// all-ones value as the base, so older detections drop out.
// Assumes: restart is only high together with upd.
module llr_min_acc #(
    parameter int METRIC_W = llr_pkg::DEF_METRIC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic                restart,
    input  logic [METRIC_W-1:0] cand0,
    input  logic [METRIC_W-1:0] cand1,
    output logic [METRIC_W-1:0] held0,
    output logic [METRIC_W-1:0] held1,
    output logic [METRIC_W-1:0] merged0,
    output logic [METRIC_W-1:0] merged1
);
    localparam logic [METRIC_W-1:0] M_MAX = '1;

    logic [METRIC_W-1:0] base0;
    logic [METRIC_W-1:0] base1;

    // Pick the base (held or reset value) and merge the batch minima, keeping held on ties.
    always_comb begin
        base0   = restart ? M_MAX : held0;
        base1   = restart ? M_MAX : held1;
        merged0 = (cand0 < base0) ? cand0 : base0;
        merged1 = (cand1 < base1) ? cand1 : base1;
    end

    // Store the merged minima on every accepted batch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held0 <= M_MAX;
            held1 <= M_MAX;
        end else if (upd) begin
            held0 <= merged0;
            held1 <= merged1;
        end
    end

    // Within a detection the held minima never grow.
    assert_min_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !restart) |=> (held0 <= $past(held0)) && (held1 <= $past(held1)));
endmodule

// File: rtl/llr_saturate.sv
// Module: signed width reduction with clamping.
// Sign-extends when the output is wide enough. Otherwise it clamps to the
// output's signed range.
// Assumes: IN_W >= 2 and OUT_W >= 2.
module llr_saturate #(
    parameter int IN_W  = llr_pkg::DEF_METRIC_W + 1,
    parameter int OUT_W = llr_pkg::DEF_LLR_W
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    if (OUT_W > IN_W) begin : g_ext
        assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else if (OUT_W == IN_W) begin : g_same
        assign dout = din;
    end else begin : g_clamp
        localparam logic signed [IN_W-1:0] HI = IN_W'((1 << (OUT_W-1)) - 1);
        localparam logic signed [IN_W-1:0] LO = ~HI;
        // Clamp out-of-range differences to the nearest representable bound.
        always_comb begin
            if (din > HI) begin
                dout = HI[OUT_W-1:0];
            end else if (din < LO) begin
                dout = LO[OUT_W-1:0];
            end else begin
                dout = din[OUT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/llr_maxlog_stream.sv
// Module: streaming max-log bit LLR unit (top).
// It folds each batch of candidates into per-bit minima for the bit=0 and
// bit=1 hypotheses and never stores the candidate list. After the last
// batch it registers min1-min0 per bit, saturated, with a one-cycle pulse.
// Assumes: the first batch of a detection carries in_first. The batch
// count per detection is fixed at NUM_BATCH.
module llr_maxlog_stream #(
    parameter int NUM_ANT   = llr_pkg::DEF_NUM_ANT,
    parameter int SYM_BITS  = llr_pkg::DEF_SYM_BITS,
    parameter int NUM_CAND  = llr_pkg::DEF_NUM_CAND,
    parameter int NUM_BATCH = llr_pkg::DEF_NUM_BATCH,
    parameter int METRIC_W  = llr_pkg::DEF_METRIC_W,
    parameter int LLR_W     = llr_pkg::DEF_LLR_W,
    localparam int LABEL_W  = NUM_ANT * SYM_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_first,
    input  logic [NUM_CAND*LABEL_W-1:0]  in_labels,
    input  logic [NUM_CAND*METRIC_W-1:0] in_metrics,
    output logic                         llr_valid,
    output logic [LABEL_W*LLR_W-1:0]     llr_out
);
    localparam int DIFF_W = METRIC_W + 1;

    logic accept;
    logic restart;
    logic last;

    llr_ctrl #(
        .NUM_BATCH (NUM_BATCH)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .accept   (accept),
        .restart  (restart),
        .last     (last),
        .done     (llr_valid)
    );

    for (genvar j = 0; j < LABEL_W; j++) begin : g_bit
        logic [NUM_CAND-1:0]      bv;
        logic [METRIC_W-1:0]      bmin0;
        logic [METRIC_W-1:0]      bmin1;
        logic [METRIC_W-1:0]      held0;
        logic [METRIC_W-1:0]      held1;
        logic [METRIC_W-1:0]      fin0;
        logic [METRIC_W-1:0]      fin1;
        logic signed [DIFF_W-1:0] diff;
        logic signed [LLR_W-1:0]  sat;
        logic signed [LLR_W-1:0]  q;

        for (genvar c = 0; c < NUM_CAND; c++) begin : g_pick
            assign bv[c] = in_labels[c*LABEL_W + j];
        end

        llr_cand_tree #(
            .NUM_CAND (NUM_CAND),
            .METRIC_W (METRIC_W)
        ) u_tree (
            .bit_vals (bv),
            .metrics  (in_metrics),
            .min0     (bmin0),
            .min1     (bmin1)
        );

        llr_min_acc #(
            .METRIC_W (METRIC_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (accept),
            .restart (restart),
            .cand0   (bmin0),
            .cand1   (bmin1),
            .held0   (held0),
            .held1   (held1),
            .merged0 (fin0),
            .merged1 (fin1)
        );

        assign diff = $signed({1'b0, fin1}) - $signed({1'b0, fin0});

        llr_saturate #(
            .IN_W  (DIFF_W),
            .OUT_W (LLR_W)
        ) u_sat (
            .din  (diff),
            .dout (sat)
        );

        // Capture this bit's LLR when the last batch is merged.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (last) begin
                q <= sat;
            end
        end

        assign llr_out[j*LLR_W +: LLR_W] = q;

        // The reported sign and zero agree with the held minima of the finished detection.
        assert_llr_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
            llr_valid |-> ((q < 0) == (held1 < held0)) && ((q == 0) == (held1 == held0)));
    end
endmodule

// File: tb/llr_maxlog_stream_tb.sv
module llr_maxlog_stream_tb;
    localparam int NA   = 2;
    localparam int SB   = 2;
    localparam int NC   = 2;
    localparam int NB   = 3;
    localparam int MW   = 4;
    localparam int LW   = 4;
    localparam int LBW  = NA * SB;
    localparam int MMAX = (1 << MW) - 1;
    localparam int LHI  = (1 << (LW-1)) - 1;
    localparam int LLO  = -(1 << (LW-1));

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  in_first = 1'b0;
    logic [NC*LBW-1:0]     in_labels = '0;
    logic [NC*MW-1:0]      in_metrics = '0;
    logic                  llr_valid;
    logic [LBW*LW-1:0]     llr_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5677;

    logic [LBW-1:0] dl [NB][NC];
    logic [MW-1:0]  dm [NB][NC];

    always #5 clk = ~clk;

    llr_maxlog_stream #(
        .NUM_ANT   (NA),
        .SYM_BITS  (SB),
        .NUM_CAND  (NC),
        .NUM_BATCH (NB),
        .METRIC_W  (MW),
        .LLR_W     (LW)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_labels  (in_labels),
        .in_metrics (in_metrics),
        .llr_valid  (llr_valid),
        .llr_out    (llr_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_rng();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
    endtask

    task automatic fill_random(input bit zero_labels);
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < NC; c++) begin
                step_rng();
                dl[b][c] = zero_labels ? '0 : seed[LBW-1:0];
                dm[b][c] = seed[8 +: MW];
            end
        end
    endtask

    // Model of R3/R8/R9: per-bit hypothesis minima, difference, clamp.
    function automatic logic [LBW*LW-1:0] expect_llr();
        logic [LBW*LW-1:0] v;
        for (int j = 0; j < LBW; j++) begin
            int mn0 = MMAX;
            int mn1 = MMAX;
            int d;
            for (int b = 0; b < NB; b++) begin
                for (int c = 0; c < NC; c++) begin
                    if (dl[b][c][j]) begin
                        if (int'(dm[b][c]) < mn1) mn1 = int'(dm[b][c]);
                    end else begin
                        if (int'(dm[b][c]) < mn0) mn0 = int'(dm[b][c]);
                    end
                end
            end
            d = mn1 - mn0;
            if (d > LHI) d = LHI;
            if (d < LLO) d = LLO;
            v[j*LW +: LW] = d[LW-1:0];
        end
        return v;
    endfunction

    task automatic drive_batch(input int b, input bit first);
        in_valid = 1'b1;
        in_first = first;
        for (int c = 0; c < NC; c++) begin
            in_labels[c*LBW +: LBW] = dl[b][c];
            in_metrics[c*MW +: MW]  = dm[b][c];
        end
    endtask

    // One detection with optional idle cycles after non-final batches (bit b of gaps).
    task automatic run_det(input int gaps, input string req);
        logic [LBW*LW-1:0] e;
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            drive_batch(b, b == 0);
            if (b < NB-1 && gaps[b]) begin
                @(negedge clk);
                in_valid = 1'b0;
                chk(llr_valid == 1'b0, "R5 no pulse during gap", 64'(llr_valid), 64'd0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        e = expect_llr();
        chk(llr_valid == 1'b1, "R4 pulse after last batch", 64'(llr_valid), 64'd1);
        chk(llr_out == e, req, 64'(llr_out), 64'(e));
        @(negedge clk);
        chk(llr_valid == 1'b0, "R4 pulse lasts one cycle", 64'(llr_valid), 64'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        logic [LBW*LW-1:0] hold_v;
        logic [LBW*LW-1:0] exp_a;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(llr_valid == 1'b0, "R1 valid low in reset", 64'(llr_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(llr_valid == 1'b0, "R1 valid low after reset", 64'(llr_valid), 64'd0);

        // R2/R3/R5: generated detections with varied gap patterns
        for (int t = 0; t < 150; t++) begin
            fill_random(1'b0);
            run_det(t % 4, "R3 R2 random detection");
        end

        // R9: sweep all minima pairs for bit 0 and bit 1 hypotheses
        for (int m0 = 0; m0 <= MMAX; m0++) begin
            for (int m1 = 0; m1 <= MMAX; m1++) begin
                for (int b = 0; b < NB; b++) begin
                    dl[b][0] = '0;
                    dl[b][1] = '1;
                    dm[b][0] = MW'(MMAX);
                    dm[b][1] = MW'(MMAX);
                end
                dm[NB-1][0] = MW'(m0);
                dm[0][1]    = MW'(m1);
                run_det(0, "R9 saturation sweep");
            end
        end

        // R8: no candidate with bit value 1
        for (int t = 0; t < 10; t++) begin
            fill_random(1'b1);
            run_det(t, "R8 missing hypothesis");
        end

        // R6: aborted detection with zero metrics must not leak into the next
        fill_random(1'b0);
        for (int b = 0; b < NB; b++) dm[b][0] = '0;
        @(negedge clk);
        drive_batch(0, 1'b1);
        @(negedge clk);
        drive_batch(1, 1'b0);
        fill_random(1'b0);
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < NC; c++) dm[b][c] = dm[b][c] | MW'(8);
        end
        run_det(0, "R6 restart discards partial");

        // R7: stray batches in idle are ignored
        hold_v = llr_out;
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < NC; c++) begin
                dl[b][c] = '1;
                dm[b][c] = '0;
            end
        end
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            drive_batch(b, 1'b0);
            chk(llr_valid == 1'b0, "R7 no pulse for stray batch", 64'(llr_valid), 64'd0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(llr_valid == 1'b0, "R7 no pulse after stray batches", 64'(llr_valid), 64'd0);
        chk(llr_out == hold_v, "R7 R4 output held", 64'(llr_out), 64'(hold_v));

        // R10: back-to-back detections
        for (int t = 0; t < 20; t++) begin
            fill_random(1'b0);
            for (int b = 0; b < NB; b++) begin
                @(negedge clk);
                drive_batch(b, b == 0);
            end
            exp_a = expect_llr();
            fill_random(1'b0);
            @(negedge clk);
            drive_batch(0, 1'b1);
            chk(llr_valid == 1'b1, "R10 first pulse", 64'(llr_valid), 64'd1);
            chk(llr_out == exp_a, "R10 first result", 64'(llr_out), 64'(exp_a));
            for (int b = 1; b < NB; b++) begin
                @(negedge clk);
                drive_batch(b, 1'b0);
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_first = 1'b0;
            chk(llr_valid == 1'b1, "R10 second pulse", 64'(llr_valid), 64'd1);
            chk(llr_out == expect_llr(), "R10 second result", 64'(llr_out), 64'(expect_llr()));
        end

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule